// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block stores the per-vector interrupt message table and the pending-bit array of a device that signals interrupts by message. Software reaches both through a dword-wide memory-mapped register port. Device logic drives one request level per vector. On a rising level the block does one of two things. It may present a message write on a valid/ready output, made of a 64-bit address, 32-bit data and the device requester ID. Otherwise it records the vector as pending.

Two inputs come from the capability register logic outside this block: a global enable and a function-wide mask. A one-cycle rescan pulse from the same logic makes the block send every vector that is pending and unmasked. Software can also release a single pending vector by writing any dword of that vector's table entry. The entry is checked again after such a write.

Each entry takes 16 bytes, as four dwords: address low (+0), address high (+4), data (+8), control (+12). Control bit 0 is the vector mask. The pending array starts at byte 16·N, straight after the last entry. The whole window is the table plus the pending array, rounded up to 4 KiB.

Top module: `msix_vector_ctl`

## Requirements
- R1: After reset, every control dword reads 1 and every other table dword reads 0. The pending array reads 0 and `msg_valid` is low.
- R2: An aligned write at byte offset 16·v+4·k with 16·v+4·k < 16·N stores the full dword into slot k of entry v. A read of that offset returns it. Read data appears on `reg_rdata` one clock after the cycle in which `reg_rd` is sampled.
- R3: Take a rising edge of `irq_lvl[v]` while `msix_en` is 1, `func_mask` is 0 and control bit 0 of v is 0. The next clock raises `msg_valid` with address {addr_high, addr_low with bits 1:0 cleared}, data equal to the data dword and `msg_rid` equal to `req_id`. The pending flag of v is cleared.
- R4: A level that stays high or falls sends no message.
- R5: Take a rising edge while enabled and either `func_mask` or control bit 0 of v is 1. It sends nothing and sets pending flag v. Vector v's flag reads as bit v of the dword at offset 16·N (for N ≤ 32).
- R6: A rising edge while `msix_en` is 0 neither sends a message nor sets a pending flag.
- R7: An accepted table write to entry v re-checks v once the write has landed. If v is pending, its mask bit is 0, `func_mask` is 0 and `msix_en` is 1, the message for v becomes valid two clocks after the write cycle and v's flag clears. Under `func_mask` the flag stays.
- R8: A `rescan` pulse sends every pending vector whose mask bit is 0 when enabled and not function-masked. Messages become valid one clock later and those flags clear.
- R9: When several vectors are waiting, the lowest index is presented first. Exactly one message leaves per clock with `msg_valid` and `msg_ready` both high. `msg_valid` stays high while messages wait.
- R10: A write at offset 16·N or above, or with offset bits 1:0 non-zero, has no effect on the table or the pending array.
- R11: A read that is misaligned or at or beyond the region end returns 0xFFFFFFFF. A read inside the region that hits neither the table nor the pending array returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset into the window |
| reg_wdata | input | 32 | Write dword |
| reg_rdata | output | 32 | Read dword, one clock after the read strobe |
| irq_lvl | input | N_VEC | Per-vector request levels |
| msix_en | input | 1 | Global enable |
| func_mask | input | 1 | Function-wide mask |
| rescan | input | 1 | Pulse: send all pending unmasked vectors |
| req_id | input | 16 | Requester ID placed in each message |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted by the consumer |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| msg_rid | output | 16 | Message requester ID |

## Verification
Each result has a fixed latency:
- A request edge shows on the message port one clock after it is sampled, as does a rescan.
- A re-check caused by a table write shows two clocks after the write, because the entry must be written before it is examined.
- Read data follows its strobe by one clock.

The bench drives every input on the falling edge. It then waits exactly that many falling edges before sampling. Pending state is examined only by reading the pending dword, once the related message activity has settled.

// File: rtl/msix_pkg.sv
package msix_pkg;

    localparam int ENTRY_BYTES = 16;
    localparam int PAGE_BYTES  = 4096;

    typedef enum logic [1:0] {
        SLOT_ADDR_LO = 2'd0,
        SLOT_ADDR_HI = 2'd1,
        SLOT_DATA    = 2'd2,
        SLOT_CTRL    = 2'd3
    } slot_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
        logic [15:0] rid;
    } msg_t;

    function automatic int pend_bytes(input int n);
        return (n + 7) / 8;
    endfunction

    function automatic int region_bytes(input int n);
        return ((n * ENTRY_BYTES + pend_bytes(n) + PAGE_BYTES - 1) / PAGE_BYTES) * PAGE_BYTES;
    endfunction

    function automatic logic [63:0] form_addr(input logic [31:0] hi, input logic [31:0] lo);
        return {hi, lo[31:2], 2'b00};
    endfunction

endpackage

// File: rtl/msix_vtab.sv
module msix_vtab
    import msix_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 16,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic [N-1:0]  pend,
    input  logic [IW-1:0] sel_idx,
    output logic [31:0]   rdata,
    output logic [N-1:0]  vmask,
    output logic          rck_hit,
    output logic [IW-1:0] rck_idx,
    output logic [31:0]   sel_lo,
    output logic [31:0]   sel_hi,
    output logic [31:0]   sel_data
);
    localparam int TAB_END = N * ENTRY_BYTES;
    localparam int PBA_DW  = (N + 31) / 32;
    localparam int PBA_END = TAB_END + PBA_DW * 4;
    localparam int REGION  = region_bytes(N);

    logic [31:0] tab [N][4];
    logic [31:0] a32;
    logic        aligned, wr_ok;
    logic [IW-1:0] ent;
    logic [1:0]  slot;
    logic [PBA_DW*32-1:0] pba_flat;
    logic [31:0] pba_word, rd_val;

    assign a32     = 32'(addr);
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_ok   = wr_en && aligned && (a32 < TAB_END);
    assign ent     = addr[IW+3:4];
    assign slot    = addr[3:2];

    always_comb begin
        pba_flat        = '0;
        pba_flat[N-1:0] = pend;
        pba_word        = '0;
        for (int k = 0; k < PBA_DW; k++)
            if (a32 == 32'(TAB_END + 4 * k)) pba_word = pba_flat[k*32 +: 32];
    end

    always_comb begin
        if (!aligned || a32 >= REGION) rd_val = 32'hFFFF_FFFF;
        else if (a32 < TAB_END)        rd_val = tab[ent][slot];
        else if (a32 < PBA_END)        rd_val = pba_word;
        else                           rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int v = 0; v < N; v++) begin
                tab[v][SLOT_ADDR_LO] <= '0;
                tab[v][SLOT_ADDR_HI] <= '0;
                tab[v][SLOT_DATA]    <= '0;
                tab[v][SLOT_CTRL]    <= 32'd1;
            end
            rck_hit <= 1'b0;
            rck_idx <= '0;
            rdata   <= '0;
        end else begin
            if (wr_ok) tab[ent][slot] <= wdata;
            rck_hit <= wr_ok;
            rck_idx <= ent;
            if (rd_en) rdata <= rd_val;
        end
    end

    for (genvar v = 0; v < N; v++) begin : g_mask
        assign vmask[v] = tab[v][SLOT_CTRL][0];
    end

    assign sel_lo   = tab[sel_idx][SLOT_ADDR_LO];
    assign sel_hi   = tab[sel_idx][SLOT_ADDR_HI];
    assign sel_data = tab[sel_idx][SLOT_DATA];

    // R10
    drop_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (!aligned || a32 >= TAB_END)) |=> $stable(vmask));

    // R11
    oob_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && a32 >= REGION) |=> (rdata == 32'hFFFF_FFFF));

endmodule

// File: rtl/msix_pend.sv
module msix_pend #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq,
    input  logic          en,
    input  logic          fmask,
    input  logic [N-1:0]  vmask,
    input  logic          rck_hit,
    input  logic [IW-1:0] rck_idx,
    input  logic          rescan,
    input  logic          take,
    input  logic [IW-1:0] take_idx,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  arm
);
    logic [N-1:0] irq_q, rise, pend_n, set_arm, clr_arm;
    logic         live;

    assign rise = irq & ~irq_q;
    assign live = en & ~fmask;

    always_comb begin
        pend_n  = pend;
        set_arm = '0;
        clr_arm = '0;
        for (int v = 0; v < N; v++) begin
            clr_arm[v] = take && (take_idx == IW'(v));
            if (rise[v] && en) begin
                if (fmask || vmask[v]) pend_n[v] = 1'b1;
                else begin
                    pend_n[v]  = 1'b0;
                    set_arm[v] = 1'b1;
                end
            end else if ((rescan || (rck_hit && rck_idx == IW'(v)))
                         && pend[v] && !vmask[v] && live) begin
                pend_n[v]  = 1'b0;
                set_arm[v] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            pend  <= '0;
            arm   <= '0;
        end else begin
            irq_q <= irq;
            pend  <= pend_n;
            arm   <= (arm & ~clr_arm) | set_arm;
        end
    end

    for (genvar v = 0; v < N; v++) begin : g_chk
        // R5
        masked_pend_chk: assert property (@(posedge clk) disable iff (rst)
            (rise[v] && en && (fmask || vmask[v])) |=> pend[v]);
        // R3
        open_send_chk: assert property (@(posedge clk) disable iff (rst)
            (rise[v] && en && !fmask && !vmask[v]) |=> (arm[v] && !pend[v]));
        // R6
        off_ignore_chk: assert property (@(posedge clk) disable iff (rst)
            (rise[v] && !en && !pend[v] && !arm[v] && !rescan && !rck_hit) |=> (!pend[v] && !arm[v]));
    end

endmodule

// File: rtl/msix_arb.sv
module msix_arb #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  arm,
    input  logic          ready,
    output logic          valid,
    output logic          take,
    output logic [IW-1:0] idx
);
    logic [N-1:0] grant_oh;
    logic         found;

    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int v = 0; v < N; v++)
            if (arm[v] && !found) begin
                idx   = IW'(v);
                found = 1'b1;
            end
    end

    assign grant_oh = arm & (~arm + N'(1));
    assign valid    = |arm;
    assign take     = valid & ready;

    // R9
    grant_one_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_oh) && (!valid || grant_oh[idx]));
    // R9
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> valid);

endmodule

// File: rtl/msix_vector_ctl.sv
module msix_vector_ctl
    import msix_pkg::*;
#(
    parameter int N_VEC  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_VEC-1:0]  irq_lvl,
    input  logic              msix_en,
    input  logic              func_mask,
    input  logic              rescan,
    input  logic [15:0]       req_id,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data,
    output logic [15:0]       msg_rid
);
    localparam int IW = (N_VEC > 1) ? $clog2(N_VEC) : 1;

    logic [N_VEC-1:0] pend, arm, vmask;
    logic             rck_hit, take;
    logic [IW-1:0]    rck_idx, sel_idx;
    logic [31:0]      sel_lo, sel_hi, sel_data;
    msg_t             msg;

    msix_vtab #(.N(N_VEC), .AW(ADDR_W), .IW(IW)) u_tab (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .pend(pend), .sel_idx(sel_idx), .rdata(reg_rdata),
        .vmask(vmask), .rck_hit(rck_hit), .rck_idx(rck_idx),
        .sel_lo(sel_lo), .sel_hi(sel_hi), .sel_data(sel_data)
    );

    msix_pend #(.N(N_VEC), .IW(IW)) u_pend (
        .clk(clk), .rst(rst), .irq(irq_lvl), .en(msix_en), .fmask(func_mask),
        .vmask(vmask), .rck_hit(rck_hit), .rck_idx(rck_idx), .rescan(rescan),
        .take(take), .take_idx(sel_idx), .pend(pend), .arm(arm)
    );

    msix_arb #(.N(N_VEC), .IW(IW)) u_arb (
        .clk(clk), .rst(rst), .arm(arm), .ready(msg_ready),
        .valid(msg_valid), .take(take), .idx(sel_idx)
    );

    always_comb begin
        msg.addr = form_addr(sel_hi, sel_lo);
        msg.data = sel_data;
        msg.rid  = req_id;
    end

    assign msg_addr = msg.addr;
    assign msg_data = msg.data;
    assign msg_rid  = msg.rid;

    // R3
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[1:0] == 2'b00));

endmodule

// File: tb/msix_vector_ctl_test.sv
module msix_vector_ctl_test;
    localparam int N = 8;
    localparam int AW = 16;
    localparam logic [AW-1:0] PBA = AW'(N * 16);

    logic clk = 0, rst = 1;
    logic reg_wr = 0, reg_rd = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [N-1:0] irq_lvl = '0;
    logic msix_en = 1, func_mask = 0, rescan = 0, msg_ready = 1;
    logic [15:0] req_id = 16'h3A15;
    logic msg_valid;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [15:0] msg_rid;

    int checks = 0, errors = 0;
    logic [31:0] m_tab [N][4];
    logic [N-1:0] m_pnd = '0;

    always #10 clk = ~clk;

    msix_vector_ctl #(.N_VEC(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lvl(irq_lvl),
        .msix_en(msix_en), .func_mask(func_mask), .rescan(rescan), .req_id(req_id),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_rid(msg_rid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_addr(input int v);
        return {m_tab[v][1], m_tab[v][0][31:2], 2'b00};
    endfunction

    task automatic msgchk(input string tag, input int v);
        chk({tag, " valid"}, 64'(msg_valid), 64'd1);
        chk({tag, " addr"}, msg_addr, exp_addr(v));
        chk({tag, " data"}, 64'(msg_data), 64'(m_tab[v][2]));
        chk({tag, " rid"}, 64'(msg_rid), 64'(req_id));
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic twr(input int v, input int k, input logic [31:0] d);
        wr(AW'(v * 16 + k * 4), d);
        m_tab[v][k] = d;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(1234));
        for (int v = 0; v < N; v++) begin
            m_tab[v][0] = 0; m_tab[v][1] = 0; m_tab[v][2] = 0; m_tab[v][3] = 1;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 msg_valid", 64'(msg_valid), 0);
        for (int v = 0; v < N; v++) begin
            rd(AW'(v * 16 + 12), d); chk("R1 ctrl", 64'(d), 1);
            rd(AW'(v * 16), d);      chk("R1 addr_lo", 64'(d), 0);
        end
        rd(PBA, d); chk("R1 pending", 64'(d), 0);

        // R2 random table writes and read-back
        for (int i = 0; i < 20; i++) begin
            int v, k;
            v = $urandom % N; k = $urandom % 3;
            twr(v, k, $urandom);
            rd(AW'(v * 16 + k * 4), d);
            chk("R2 readback", 64'(d), 64'(m_tab[v][k]));
        end
        for (int v = 0; v < N; v++) begin
            twr(v, 0, $urandom | 32'h3); twr(v, 1, $urandom); twr(v, 2, $urandom); twr(v, 3, 0);
        end
        rd(AW'(5 * 16 + 12), d); chk("R2 ctrl readback", 64'(d), 0);

        // R3 / R4 unmasked edges
        for (int i = 0; i < 6; i++) begin
            int v;
            v = $urandom % N;
            @(negedge clk); irq_lvl[v] = 1;
            @(negedge clk); msgchk("R3 send", v);
            @(negedge clk); chk("R4 held high", 64'(msg_valid), 0);
            irq_lvl[v] = 0;
            @(negedge clk); chk("R4 falling", 64'(msg_valid), 0);
        end

        // R6 disabled
        msix_en = 0;
        @(negedge clk); irq_lvl[2] = 1;
        @(negedge clk); chk("R6 no send", 64'(msg_valid), 0);
        irq_lvl[2] = 0; msix_en = 1;
        rd(PBA, d); chk("R6 no pending", 64'(d), 0);

        // R5 vector mask and function mask
        twr(3, 3, 1);
        @(negedge clk); irq_lvl[3] = 1;
        @(negedge clk); chk("R5 vmask no send", 64'(msg_valid), 0);
        irq_lvl[3] = 0; func_mask = 1;
        @(negedge clk); irq_lvl[5] = 1;
        @(negedge clk); chk("R5 fmask no send", 64'(msg_valid), 0);
        irq_lvl[5] = 0;
        m_pnd[3] = 1; m_pnd[5] = 1;
        rd(PBA, d); chk("R5 pending bits", 64'(d), 64'(m_pnd));

        // R10 discarded writes
        wr(PBA, 32'h0);
        rd(PBA, d); chk("R10 pending write dropped", 64'(d), 64'(m_pnd));
        wr(AW'(3 * 16 + 13), 32'h0);
        rd(AW'(3 * 16 + 12), d); chk("R10 misaligned dropped", 64'(d), 1);
        wr(16'h0800, 32'h0);
        rd(AW'(3 * 16 + 12), d); chk("R10 far write dropped", 64'(d), 1);

        // R7 re-check on table write
        twr(3, 3, 0);
        @(negedge clk); chk("R7 fmask holds", 64'(msg_valid), 0);
        func_mask = 0;
        @(negedge clk); chk("R7 no spontaneous", 64'(msg_valid), 0);
        twr(3, 3, 0);
        @(negedge clk); msgchk("R7 recheck send", 3);
        m_pnd[3] = 0;
        @(negedge clk); chk("R7 single", 64'(msg_valid), 0);
        rd(PBA, d); chk("R7 pending cleared", 64'(d), 64'(m_pnd));

        // R8 rescan, R9 ordering
        func_mask = 1;
        @(negedge clk); irq_lvl[1] = 1;
        @(negedge clk); irq_lvl[1] = 0; func_mask = 0; m_pnd[1] = 1;
        chk("R8 fmask no send", 64'(msg_valid), 0);
        msg_ready = 0; rescan = 1;
        @(negedge clk); rescan = 0;
        msgchk("R8 rescan lowest", 1);
        @(negedge clk); msgchk("R9 held", 1);
        msg_ready = 1;
        @(negedge clk); msgchk("R8 rescan second", 5);
        @(negedge clk); chk("R8 drained", 64'(msg_valid), 0);
        m_pnd = '0;
        rd(PBA, d); chk("R8 pending cleared", 64'(d), 0);

        msg_ready = 0;
        @(negedge clk); irq_lvl[7] = 1; irq_lvl[4] = 1; irq_lvl[6] = 1;
        @(negedge clk); msgchk("R9 first", 4);
        @(negedge clk); msgchk("R9 wait", 4);
        msg_ready = 1;
        @(negedge clk); msgchk("R9 second", 6);
        @(negedge clk); msgchk("R9 third", 7);
        @(negedge clk); chk("R9 empty", 64'(msg_valid), 0);
        irq_lvl = '0;

        // R11 reads
        rd(16'h1000, d); chk("R11 past end", 64'(d), 64'hFFFF_FFFF);
        rd(16'h0002, d); chk("R11 misaligned", 64'(d), 64'hFFFF_FFFF);
        rd(16'h0800, d); chk("R11 gap", 64'(d), 0);
        rd(16'h0FFC, d); chk("R11 last dword", 64'(d), 0);

        // random masks mixed with edges (R3 R5 R7)
        for (int i = 0; i < 30; i++) begin
            int v;
            logic m;
            v = $urandom % N; m = 1'($urandom % 2);
            twr(v, 3, 32'(m));
            @(negedge clk);
            if (m_pnd[v] && !m) begin
                msgchk("R7 random recheck", v);
                m_pnd[v] = 0;
            end else chk("R7 random quiet", 64'(msg_valid), 0);
            irq_lvl[v] = 1;
            @(negedge clk);
            if (m) begin
                chk("R5 random masked", 64'(msg_valid), 0);
                m_pnd[v] = 1;
            end else msgchk("R3 random send", v);
            irq_lvl[v] = 0;
            @(negedge clk); chk("R4 random idle", 64'(msg_valid), 0);
        end
        rd(PBA, d); chk("R5 random pending", 64'(d), 64'(m_pnd));

        summary();
    end
endmodule